// File: doc/BRIEF.md
# USB Host Interrupt Status Aggregator

This block gathers every interrupt source of a USB host controller into one status word and one interrupt request line. The sources are one host wake-up flag, seven per-pipe flags (pipes 0 to 6) and six per-DMA-channel flags (channels 1 to 6). The pipe and DMA flags follow the level of their underlying sources. The hardware clears them when the source is serviced or when the channel status is cleared.

The wake-up flag reacts only to bus events that fit the controller's power state. It is set by an upstream resume or a device disconnection while the host is suspended, which means start-of-frame generation is off. It is also set by a session request from the device while the host is idle, which means no VBUS is requested. The flag is captured by an asynchronous set flop, so an event is caught even while the module clock is frozen. The flop output then passes through a two-flop synchronizer into the running clock domain. Software clears the flag through a clear strobe.

Each status bit has its own enable bit. The interrupt request is the registered OR of all enabled status bits.

Top module: `usb_host_irq_agg`

## Requirements
- R1: After reset, `status` and `irq` are all zero.
- R2: A pulse on `resumeEvt` while `sofEnable` is 0 sets status bit 0 (the wake-up flag). The bit reads 1 from the second rising clock edge after the pulse and still reads 0 after the first edge.
- R3: A pulse on `disconnEvt` while `sofEnable` is 0 sets status bit 0, with the same timing as R2.
- R4: A pulse on `srpEvt` while `vbusReq` is 0 sets status bit 0, with the same timing as R2.
- R5: The following events leave status bit 0 at 0: `resumeEvt` or `disconnEvt` while `sofEnable` is 1, and `srpEvt` while `vbusReq` is 1.
- R6: While `clkFreeze` is 1, a qualified wake-up event still sets status bit 0. During the freeze the pipe and DMA status fields hold their values, and `wakeClr` has no effect.
- R7: While `clkFreeze` is 0, the pipe field `status[7:1]` (pipe i at bit 1+i) and the DMA field `status[13:8]` (channel k at bit 7+k) equal `pipeSrc` and `dmaSrc` as sampled at the previous rising edge. A source that returns to 0 clears its flag.
- R8: A `wakeClr` of 1 sampled at a rising edge while `clkFreeze` is 0 clears the wake-up flag. Status bit 0 reads 0 from the third edge onward and still reads 1 after the second edge. If a qualified event is active during the same cycle as the clear, the set wins.
- R9: `irq` equals the OR of (`status` AND `intEn`) as sampled at the previous rising edge. Bit positions of `intEn` match those of `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Running clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkFreeze | input | 1 | Freezes flag capture and software clear |
| sofEnable | input | 1 | Start-of-frame generation on; 0 means suspended |
| vbusReq | input | 1 | VBUS requested; 0 means idle |
| resumeEvt | input | 1 | Upstream resume event pulse |
| disconnEvt | input | 1 | Device disconnection event pulse |
| srpEvt | input | 1 | Session request event pulse |
| pipeSrc | input | 7 | Per-pipe interrupt source levels |
| dmaSrc | input | 6 | Per-DMA-channel source levels (bit 0 is channel 1) |
| wakeClr | input | 1 | Software clear strobe for the wake-up flag |
| intEn | input | 14 | Per-status-bit interrupt enables |
| status | output | 14 | Aggregated status word |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: seven pipes, six DMA channels and a two-stage synchronizer. At this size the highest pipe bit and the highest DMA bit can each be checked, and the synchronizer delay can be observed edge by edge. Each wake-up event type is driven both inside and outside its qualifying power state. Further cases are a capture and a blocked clear while frozen, and a clear that collides with a held event.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  // Strobes that the control half hands to the datapath half
  typedef struct packed {
    logic wakeSet;   // qualified wake-up event, level, asynchronous
    logic wakeClr;   // accepted software clear
    logic capture;   // module clock running: flags may update
  } ctrlStrobes_t;
endpackage

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
(
  input  logic         clkFreeze,
  input  logic         sofEnable,
  input  logic         vbusReq,
  input  logic         resumeEvt,
  input  logic         disconnEvt,
  input  logic         srpEvt,
  input  logic         wakeClr,
  output ctrlStrobes_t strb
);
  logic suspended;
  logic idle;
  logic busEvt;
  logic sessEvt;

  always_comb begin
    suspended    = !sofEnable;
    idle         = !vbusReq;
    busEvt       = suspended & (resumeEvt | disconnEvt);
    sessEvt      = idle & srpEvt;
    strb.wakeSet = busEvt | sessEvt;
    strb.wakeClr = wakeClr & !clkFreeze;
    strb.capture = !clkFreeze;
  end
endmodule

// File: rtl/usb_irq_datapath.sv
module usb_irq_datapath
  import usb_irq_pkg::*;
#(
  parameter int NUM_PIPES   = 7,
  parameter int NUM_DMA     = 6,
  parameter int SYNC_STAGES = 2,
  localparam int STATUS_W   = 1 + NUM_PIPES + NUM_DMA
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strb,
  input  logic [NUM_PIPES-1:0] pipeSrc,
  input  logic [NUM_DMA-1:0]   dmaSrc,
  input  logic [STATUS_W-1:0]  intEn,
  output logic [STATUS_W-1:0]  status,
  output logic                 irq
);
  logic                   wakeSetAsync;
  logic                   wakeRaw;
  logic [SYNC_STAGES-1:0] wakeSync;
  logic [NUM_PIPES-1:0]   pipeQ;
  logic [NUM_DMA-1:0]     dmaQ;
  logic                   irqQ;

  assign wakeSetAsync = strb.wakeSet;

  // Asynchronous-set capture flop: catches events with the clock frozen
  always_ff @(posedge clk or negedge rstN or posedge wakeSetAsync) begin
    if (!rstN)             wakeRaw <= 1'b0;
    else if (wakeSetAsync) wakeRaw <= 1'b1;
    else if (strb.wakeClr) wakeRaw <= 1'b0;
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) wakeSync[s] <= 1'b0;
        else       wakeSync[s] <= (s == 0) ? wakeRaw : wakeSync[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeQ <= '0;
      dmaQ  <= '0;
    end else if (strb.capture) begin
      pipeQ <= pipeSrc;
      dmaQ  <= dmaSrc;
    end
  end

  assign status = {dmaQ, pipeQ, wakeSync[SYNC_STAGES-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(status & intEn);
  end

  assign irq = irqQ;
endmodule

// File: rtl/usb_host_irq_agg.sv
module usb_host_irq_agg
  import usb_irq_pkg::*;
#(
  parameter int NUM_PIPES   = 7,
  parameter int NUM_DMA     = 6,
  parameter int SYNC_STAGES = 2,
  localparam int STATUS_W   = 1 + NUM_PIPES + NUM_DMA
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkFreeze,
  input  logic                 sofEnable,
  input  logic                 vbusReq,
  input  logic                 resumeEvt,
  input  logic                 disconnEvt,
  input  logic                 srpEvt,
  input  logic [NUM_PIPES-1:0] pipeSrc,
  input  logic [NUM_DMA-1:0]   dmaSrc,
  input  logic                 wakeClr,
  input  logic [STATUS_W-1:0]  intEn,
  output logic [STATUS_W-1:0]  status,
  output logic                 irq
);
  ctrlStrobes_t strb;

  usb_irq_ctrl i_ctrl (
    .clkFreeze (clkFreeze),
    .sofEnable (sofEnable),
    .vbusReq   (vbusReq),
    .resumeEvt (resumeEvt),
    .disconnEvt(disconnEvt),
    .srpEvt    (srpEvt),
    .wakeClr   (wakeClr),
    .strb      (strb)
  );

  usb_irq_datapath #(
    .NUM_PIPES  (NUM_PIPES),
    .NUM_DMA    (NUM_DMA),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .pipeSrc(pipeSrc),
    .dmaSrc (dmaSrc),
    .intEn  (intEn),
    .status (status),
    .irq    (irq)
  );
endmodule

// File: rtl/usb_irq_chk.sv
module usb_irq_chk #(
  parameter int NUM_PIPES = 7,
  parameter int NUM_DMA   = 6,
  localparam int STATUS_W = 1 + NUM_PIPES + NUM_DMA
)(
  input logic                 clk,
  input logic                 rstN,
  input logic                 clkFreeze,
  input logic                 wakeClr,
  input logic [NUM_PIPES-1:0] pipeSrc,
  input logic [NUM_DMA-1:0]   dmaSrc,
  input logic [STATUS_W-1:0]  intEn,
  input logic [STATUS_W-1:0]  status,
  input logic                 irq
);
  // R7: running clock, flag fields track the sampled sources
  p_flags_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    !clkFreeze |=> status[STATUS_W-1:1] == $past({dmaSrc, pipeSrc}));

  // R6: frozen clock, flag fields hold
  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    clkFreeze |=> $stable(status[STATUS_W-1:1]));

  // R9: a raised request needs an enabled status bit one edge earlier
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(|(status & intEn)));

  // R8: the wake-up flag only drops three edges after an accepted clear
  // (depth matches the default two-stage synchronizer)
  p_wake_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[0]) |-> $past(wakeClr && !clkFreeze, 3));
endmodule

bind usb_host_irq_agg usb_irq_chk #(
  .NUM_PIPES(NUM_PIPES),
  .NUM_DMA  (NUM_DMA)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clkFreeze(clkFreeze),
  .wakeClr  (wakeClr),
  .pipeSrc  (pipeSrc),
  .dmaSrc   (dmaSrc),
  .intEn    (intEn),
  .status   (status),
  .irq      (irq)
);

// File: tb/test_usb_host_irq_agg.sv
module test_usb_host_irq_agg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkFreeze = 1'b0;
  logic        sofEnable = 1'b1;
  logic        vbusReq = 1'b1;
  logic        resumeEvt = 1'b0;
  logic        disconnEvt = 1'b0;
  logic        srpEvt = 1'b0;
  logic [6:0]  pipeSrc = '0;
  logic [5:0]  dmaSrc = '0;
  logic        wakeClr = 1'b0;
  logic [13:0] intEn = '0;
  logic [13:0] status;
  logic        irq;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          at;
    logic [13:0] st;
    logic        irqv;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usb_host_irq_agg i_usb_host_irq_agg (
    .clk(clk), .rstN(rstN), .clkFreeze(clkFreeze), .sofEnable(sofEnable),
    .vbusReq(vbusReq), .resumeEvt(resumeEvt), .disconnEvt(disconnEvt),
    .srpEvt(srpEvt), .pipeSrc(pipeSrc), .dmaSrc(dmaSrc), .wakeClr(wakeClr),
    .intEn(intEn), .status(status), .irq(irq)
  );

  function automatic logic [13:0] stw(logic w, logic [6:0] p, logic [5:0] d);
    return {d, p, w};
  endfunction

  // Driver side: push an expectation some cycles ahead
  task automatic expect_at(int ofs, logic [13:0] st, logic irqv, string tag);
    item_t it;
    it.at = cyc + ofs; it.st = st; it.irqv = irqv; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 resume, 1 disconnect, 2 session request; short pulse between edges
  task automatic pulse(int which);
    case (which)
      0: resumeEvt = 1'b1;
      1: disconnEvt = 1'b1;
      default: srpEvt = 1'b1;
    endcase
    #1;
    resumeEvt = 1'b0; disconnEvt = 1'b0; srpEvt = 1'b0;
  endtask

  task automatic clearWake();
    wakeClr = 1'b1;
    waitc(1);
    wakeClr = 1'b0;
  endtask

  // Monitor side: pop and compare due items
  always @(negedge clk) begin
    #0.5;
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (status !== it.st || irq !== it.irqv) begin
        errors++;
        $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                 it.tag, status, irq, it.st, it.irqv);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    waitc(3);
    rstN = 1'b1;
    expect_at(1, 14'h0, 1'b0, "R1 reset state");
    waitc(3);

    // R7: pipes 0 and 2, DMA channels 1 and 6
    pipeSrc = 7'h05; dmaSrc = 6'h21;
    expect_at(1, stw(0, 7'h05, 6'h21), 1'b0, "R7 flags follow sources");
    waitc(3);

    // R9: enable pipe 0 (bit 1)
    intEn = 14'h0002;
    expect_at(1, stw(0, 7'h05, 6'h21), 1'b1, "R9 enabled pipe raises irq");
    waitc(3);

    // R7: source served -> flag cleared; irq follows one edge later
    pipeSrc = 7'h04;
    expect_at(1, stw(0, 7'h04, 6'h21), 1'b1, "R7 pipe flag clears");
    expect_at(2, stw(0, 7'h04, 6'h21), 1'b0, "R9 irq drops after flag");
    waitc(3);

    // R9: enable DMA channel 6 (bit 13), highest bit
    intEn = 14'h2000;
    expect_at(1, stw(0, 7'h04, 6'h21), 1'b1, "R9 enabled DMA ch6 raises irq");
    waitc(3);
    intEn = 14'h0000;
    expect_at(1, stw(0, 7'h04, 6'h21), 1'b0, "R9 disabled enable drops irq");
    waitc(3);
    pipeSrc = 7'h00; dmaSrc = 6'h00;
    waitc(3);

    // R2: resume in suspend
    sofEnable = 1'b0;
    pulse(0);
    expect_at(1, stw(0, 0, 0), 1'b0, "R2 wake not yet after one edge");
    expect_at(2, stw(1, 0, 0), 1'b0, "R2 resume in suspend sets wake");
    waitc(4);

    // R8: software clear
    clearWake();
    expect_at(1, stw(1, 0, 0), 1'b0, "R8 wake still set after two edges");
    expect_at(2, stw(0, 0, 0), 1'b0, "R8 clear drops wake");
    waitc(4);

    // R3: disconnect in suspend, with wake enable
    intEn = 14'h0001;
    pulse(1);
    expect_at(2, stw(1, 0, 0), 1'b0, "R3 disconnect in suspend sets wake");
    expect_at(3, stw(1, 0, 0), 1'b1, "R9 wake enabled raises irq");
    waitc(4);
    clearWake();
    expect_at(2, stw(0, 0, 0), 1'b1, "R8 wake cleared, irq lags");
    expect_at(3, stw(0, 0, 0), 1'b0, "R9 irq drops after wake clear");
    waitc(4);
    intEn = 14'h0000;

    // R5: unqualified events
    sofEnable = 1'b1; vbusReq = 1'b1;
    pulse(0); waitc(1);
    pulse(1); waitc(1);
    pulse(2);
    expect_at(3, stw(0, 0, 0), 1'b0, "R5 events outside their state ignored");
    waitc(4);
    sofEnable = 1'b0;
    pulse(2);
    expect_at(3, stw(0, 0, 0), 1'b0, "R5 SRP in suspend with VBUS ignored");
    waitc(4);
    sofEnable = 1'b1;

    // R4: SRP while idle
    vbusReq = 1'b0;
    pulse(2);
    expect_at(2, stw(1, 0, 0), 1'b0, "R4 SRP in idle sets wake");
    waitc(4);
    clearWake();
    expect_at(2, stw(0, 0, 0), 1'b0, "R8 clear after SRP wake");
    waitc(4);
    vbusReq = 1'b1;

    // R6: frozen clock
    sofEnable = 1'b0;
    clkFreeze = 1'b1;
    pipeSrc = 7'h40; dmaSrc = 6'h01;
    expect_at(1, stw(0, 0, 0), 1'b0, "R6 frozen flags hold");
    waitc(1);
    pulse(0);
    expect_at(2, stw(1, 0, 0), 1'b0, "R6 wake captured while frozen");
    waitc(3);
    clearWake();
    expect_at(3, stw(1, 0, 0), 1'b0, "R6 clear ignored while frozen");
    waitc(4);
    clkFreeze = 1'b0;
    expect_at(1, stw(1, 7'h40, 6'h01), 1'b0, "R7 pipe 6 and DMA ch1 after unfreeze");
    waitc(3);
    clearWake();
    expect_at(2, stw(0, 7'h40, 6'h01), 1'b0, "R8 clear after unfreeze");
    waitc(4);

    // R8: set wins over a simultaneous clear
    resumeEvt = 1'b1; wakeClr = 1'b1;
    waitc(1);
    resumeEvt = 1'b0; wakeClr = 1'b0;
    expect_at(3, stw(1, 7'h40, 6'h01), 1'b0, "R8 set wins over clear");
    waitc(5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule